// File: doc/BRIEF.md
# Read-Modify-Write Operation Unit

This block carries out one read-modify-write step on a bus target. A decoded descriptor word, together with a target address, a write value and a mask, is presented on a start strobe. The unit reads the addressed location over a single-beat bus master port. It computes a new value with one of eleven update methods and writes that value back to the same address.

The update methods are:
- a masked merge, `(read & ~mask) | value`;
- increment and decrement;
- one-place shifts and rotates;
- inversion;
- XOR, OR and AND with the mask.

The operation always runs in strict order: read, then compute, then write. The write is never issued before the read data has come back. An error response on either bus beat ends the operation without a write and raises an error flag. The flag stays up until the next accepted descriptor.

The data width is a parameter, so the same unit serves narrow test configurations and the full 32-bit target.

Top module: `rmw_unit`

## Requirements
- R1: After reset the unit is idle: `busy_o`, `bus_req_o`, `done_o` and `err_o` are all low.
- R2: A start is accepted only when descriptor bits [2:0] hold the write opcode 1. A start with any other opcode is ignored: no bus request is made, `busy_o` stays low and `err_o` keeps its value.
- R3: An accepted operation reads from `addr_i` first and then writes to the same address. The write request is raised only after the read has been acknowledged.
- R4: The method is taken from descriptor bits [11:8]. Method 0 writes `(read & ~mask) | value`. Method codes 11 to 15 behave exactly as method 0.
- R5: Method 1 writes read+1 and method 2 writes read-1, both wrapping modulo 2^DATA_W.
- R6: Method 3 writes read shifted right by one and method 4 writes read shifted left by one, each filling the vacated bit with 0.
- R7: Method 5 rotates right by one (bit 0 moves to the top bit). Method 6 rotates left by one (the top bit moves to bit 0).
- R8: Methods 7, 8, 9 and 10 write ~read, read^mask, read|mask and read&mask.
- R9: An error response to the read ends the operation with `done_o` and `err_o` high and no write request.
- R10: An error response to the write ends the operation with `done_o` and `err_o` high.
- R11: `done_o` is a one-cycle pulse per finished operation. `err_o` holds its value until the next accepted start, which clears it.
- R12: While a request is waiting for a response, `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe presenting a descriptor |
| desc_i | input | 32 | Decoded descriptor word (opcode [2:0], method [11:8]) |
| addr_i | input | ADDR_W | Target address |
| wval_i | input | DATA_W | Write value operand |
| mask_i | input | DATA_W | Mask operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Bus error flag of the last accepted operation |
| bus_req_o | output | 1 | Bus request, held until ack or error |
| bus_we_o | output | 1 | Request is a write |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Successful response |
| bus_err_i | input | 1 | Error response |
| bus_rdata_i | input | DATA_W | Read data, valid with ack |

## Verification
The bench builds the unit with DATA_W=8 and ADDR_W=8. At that width every one of the 256 read values can be driven through each of the 16 method codes, including the five aliases of method 0. This reaches every wrap, shift-out and rotate carry, for example 0xFF+1 and 0x00-1. The memory model varies its response latency from zero to two cycles, and errors are injected on the read beat and on the write beat.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    localparam int DESC_W    = 32;
    localparam int OPC_LSB   = 0;
    localparam int OPC_W     = 3;
    localparam int MTH_LSB   = 8;
    localparam int MTH_W     = 4;
    localparam logic [OPC_W-1:0] OPC_RMW = 3'd1;

    typedef enum logic [MTH_W-1:0] {
        M_MERGE = 4'd0,
        M_INC   = 4'd1,
        M_DEC   = 4'd2,
        M_SHR   = 4'd3,
        M_SHL   = 4'd4,
        M_ROR   = 4'd5,
        M_ROL   = 4'd6,
        M_INV   = 4'd7,
        M_XOR   = 4'd8,
        M_OR    = 4'd9,
        M_AND   = 4'd10
    } rmw_method_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_CALC  = 2'd2,
        ST_WRITE = 2'd3
    } rmw_state_e;
endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
    import rmw_pkg::*;
(
    input  logic [DESC_W-1:0] desc_i,
    output logic              is_rmw_o,
    output logic [MTH_W-1:0]  method_o
);
    logic unused_desc_bits;
    assign unused_desc_bits = ^{desc_i[DESC_W-1:MTH_LSB+MTH_W], desc_i[MTH_LSB-1:OPC_LSB+OPC_W]};

    always_comb begin
        is_rmw_o = (desc_i[OPC_LSB +: OPC_W] == OPC_RMW);
        method_o = desc_i[MTH_LSB +: MTH_W];
    end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [MTH_W-1:0]  method_i,
    input  logic [DATA_W-1:0] rd_i,
    input  logic [DATA_W-1:0] wval_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] res_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        case (method_i)
            M_INC:   res_o = rd_i + ONE;
            M_DEC:   res_o = rd_i - ONE;
            M_SHR:   res_o = rd_i >> 1;
            M_SHL:   res_o = rd_i << 1;
            M_ROR:   res_o = {rd_i[0], rd_i[DATA_W-1:1]};
            M_ROL:   res_o = {rd_i[DATA_W-2:0], rd_i[DATA_W-1]};
            M_INV:   res_o = ~rd_i;
            M_XOR:   res_o = rd_i ^ mask_i;
            M_OR:    res_o = rd_i | mask_i;
            M_AND:   res_o = rd_i & mask_i;
            default: res_o = (rd_i & ~mask_i) | wval_i;
        endcase
    end

    // R5: increment result differs from read by exactly one, modulo width
    always_comb begin
        if (method_i == M_INC)
            p_inc_wrap_r5: assert (res_o - rd_i == ONE);
    end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import rmw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_rmw_i,
    input  logic [MTH_W-1:0]  method_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wval_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] alu_res_i,
    output logic [MTH_W-1:0]  alu_method_o,
    output logic [DATA_W-1:0] alu_rd_o,
    output logic [DATA_W-1:0] alu_wval_o,
    output logic [DATA_W-1:0] alu_mask_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    typedef struct packed {
        rmw_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [MTH_W-1:0]  mth;
        logic [DATA_W-1:0] wval;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rdat;
        logic [DATA_W-1:0] res;
        logic              done;
        logic              err;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  accept;

    assign accept = start_i && is_rmw_i && (r_q.st == ST_IDLE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st   = ST_READ;
                    r_d.addr = addr_i;
                    r_d.mth  = method_i;
                    r_d.wval = wval_i;
                    r_d.mask = mask_i;
                    r_d.err  = 1'b0;
                end
            end
            ST_READ: begin
                if (bus_err_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                end else if (bus_ack_i) begin
                    r_d.st   = ST_CALC;
                    r_d.rdat = bus_rdata_i;
                end
            end
            ST_CALC: begin
                r_d.res = alu_res_i;
                r_d.st  = ST_WRITE;
            end
            ST_WRITE: begin
                if (bus_err_i || bus_ack_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = bus_err_i;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        alu_method_o = r_q.mth;
        alu_rd_o     = r_q.rdat;
        alu_wval_o   = r_q.wval;
        alu_mask_o   = r_q.mask;
        busy_o       = (r_q.st != ST_IDLE);
        done_o       = r_q.done;
        err_o        = r_q.err;
        bus_req_o    = (r_q.st == ST_READ) || (r_q.st == ST_WRITE);
        bus_we_o     = (r_q.st == ST_WRITE);
        bus_addr_o   = r_q.addr;
        bus_wdata_o  = r_q.res;
    end

    // Independent record of a completed read beat in the current operation
    logic rd_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_seen_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            rd_seen_q <= 1'b0;
        end else if (bus_req_o && !bus_we_o && bus_ack_i && !bus_err_i) begin
            rd_seen_q <= 1'b1;
        end
    end

    // R3: no write request before the read has been acknowledged
    p_write_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_we_o) |-> rd_seen_q);

    // R12: a pending request holds its attributes
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i && !bus_err_i) |=>
            (bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)));

    // R9: an errored read is never followed by a write
    p_read_err_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_we_o && bus_err_i) |=> (!bus_req_o && done_o && err_o));

    // R11: completion pulse lasts one cycle and never overlaps a request
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!bus_req_o && !busy_o));

    // R2: an idle start with a foreign opcode leaves the unit idle
    p_foreign_opc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !is_rmw_i && !busy_o) |=> (!busy_o && $stable(err_o)));
endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
    import rmw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       desc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wval_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    logic              is_rmw;
    logic [MTH_W-1:0]  dec_method;
    logic [MTH_W-1:0]  alu_method;
    logic [DATA_W-1:0] alu_rd, alu_wval, alu_mask, alu_res;

    rmw_decode u_decode (
        .desc_i   (desc_i),
        .is_rmw_o (is_rmw),
        .method_o (dec_method)
    );

    rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .method_i (alu_method),
        .rd_i     (alu_rd),
        .wval_i   (alu_wval),
        .mask_i   (alu_mask),
        .res_o    (alu_res)
    );

    rmw_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .is_rmw_i     (is_rmw),
        .method_i     (dec_method),
        .addr_i       (addr_i),
        .wval_i       (wval_i),
        .mask_i       (mask_i),
        .alu_res_i    (alu_res),
        .alu_method_o (alu_method),
        .alu_rd_o     (alu_rd),
        .alu_wval_o   (alu_wval),
        .alu_mask_o   (alu_mask),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .bus_req_o    (bus_req_o),
        .bus_we_o     (bus_we_o),
        .bus_addr_o   (bus_addr_o),
        .bus_wdata_o  (bus_wdata_o),
        .bus_ack_i    (bus_ack_i),
        .bus_err_i    (bus_err_i),
        .bus_rdata_i  (bus_rdata_i)
    );

    // R1: reset leaves the bus quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bus_req_o && !busy_o));
endmodule

// File: tb/rmw_unit_tb.sv
module rmw_unit_tb;
    localparam int DW = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   desc = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wval = '0, mask = '0;
    logic          busy, done, err, req, we;
    logic [AW-1:0] baddr;
    logic [DW-1:0] wdata;
    logic          ack, berr;
    logic [DW-1:0] rdata;

    always #2.5 clk = ~clk;

    rmw_unit #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .desc_i(desc),
        .addr_i(addr), .wval_i(wval), .mask_i(mask),
        .busy_o(busy), .done_o(done), .err_o(err),
        .bus_req_o(req), .bus_we_o(we), .bus_addr_o(baddr), .bus_wdata_o(wdata),
        .bus_ack_i(ack), .bus_err_i(berr), .bus_rdata_i(rdata)
    );

    // Memory-like slave holding a single location
    logic [DW-1:0] mem;
    logic          load = 1'b0;
    logic [DW-1:0] load_val = '0;
    int            lat = 0;
    logic          err_rd = 1'b0, err_wr = 1'b0;
    int            wait_cnt;
    int            n_wr, n_rd;
    logic          order_bad, req_seen;
    logic          clr_mon = 1'b0;
    logic [AW-1:0] rd_addr_s, wr_addr_s;

    always @(posedge clk) begin
        if (load) mem <= load_val;
        if (clr_mon) begin
            n_wr <= 0; n_rd <= 0; order_bad <= 1'b0; req_seen <= 1'b0;
        end
        if (req) req_seen <= 1'b1;
        if (ack || berr) begin
            ack <= 1'b0; berr <= 1'b0; wait_cnt <= 0;
        end else if (req) begin
            if (wait_cnt >= lat) begin
                wait_cnt <= 0;
                if (we) begin
                    if (n_rd == 0) order_bad <= 1'b1;
                    wr_addr_s <= baddr;
                    if (err_wr) berr <= 1'b1;
                    else begin ack <= 1'b1; mem <= wdata; n_wr <= n_wr + 1; end
                end else begin
                    rd_addr_s <= baddr;
                    if (err_rd) berr <= 1'b1;
                    else begin ack <= 1'b1; rdata <= mem; n_rd <= n_rd + 1; end
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model(input int m, input logic [DW-1:0] r,
                                            input logic [DW-1:0] w, input logic [DW-1:0] k);
        case (m)
            1:  return r + 8'd1;
            2:  return r - 8'd1;
            3:  return r >> 1;
            4:  return r << 1;
            5:  return {r[0], r[DW-1:1]};
            6:  return {r[DW-2:0], r[DW-1]};
            7:  return ~r;
            8:  return r ^ k;
            9:  return r | k;
            10: return r & k;
            default: return (r & ~k) | w;
        endcase
    endfunction

    task automatic preload(input logic [DW-1:0] v);
        @(negedge clk);
        load = 1'b1; load_val = v; clr_mon = 1'b1;
        @(negedge clk);
        load = 1'b0; clr_mon = 1'b0;
    endtask

    // Issue a descriptor and wait for done; returns 1 when done was seen
    task automatic run(input logic [2:0] opc, input int m, input logic [AW-1:0] a,
                       input logic [DW-1:0] w, input logic [DW-1:0] k, output bit seen);
        desc = '0;
        desc[2:0] = opc;
        desc[11:8] = 4'(m);
        desc[31:24] = 8'hA5;
        addr = a; wval = w; mask = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit seen;
        logic [DW-1:0] r, w, k, exp;
        ack = 1'b0; berr = 1'b0; rdata = '0; wait_cnt = 0;
        n_wr = 0; n_rd = 0; order_bad = 1'b0; req_seen = 1'b0; mem = '0;
        rd_addr_s = '0; wr_addr_s = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !req && !done && !err, "R1", {busy, req, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req && !done && !err, "R1", {busy, req, done, err}, 0);

        // R4 R5 R6 R7 R8: full sweep of method codes and read values
        for (int m = 0; m < 16; m++) begin
            for (int v = 0; v < 256; v++) begin
                r = 8'(v);
                w = 8'(v * 37 + m * 11 + 5);
                k = 8'(v * 91 + m * 29 + 3);
                exp = model(m, r, w, k);
                lat = (v + m) % 3;
                preload(r);
                run(3'd1, m, 8'(v ^ 8'h5C), w, k, seen);
                if (m == 0 || m > 10)
                    check(seen && mem == exp, "R4", mem, exp);
                else if (m <= 2)
                    check(seen && mem == exp, "R5", mem, exp);
                else if (m <= 4)
                    check(seen && mem == exp, "R6", mem, exp);
                else if (m <= 6)
                    check(seen && mem == exp, "R7", mem, exp);
                else
                    check(seen && mem == exp, "R8", mem, exp);
                if (v % 64 == 0) begin
                    // R3: read before write, same address, one of each
                    check(!order_bad && n_rd == 1 && n_wr == 1, "R3", {n_rd, n_wr}, 32'h11);
                    check(rd_addr_s == 8'(v ^ 8'h5C) && wr_addr_s == rd_addr_s,
                          "R3", wr_addr_s, 8'(v ^ 8'h5C));
                    // R11: done lasts one cycle
                    @(negedge clk);
                    check(!done && !err, "R11", {done, err}, 0);
                end
            end
        end

        // R5: wrap corners
        preload(8'hFF); run(3'd1, 1, 8'h10, 0, 0, seen);
        check(mem == 8'h00, "R5", mem, 0);
        preload(8'h00); run(3'd1, 2, 8'h10, 0, 0, seen);
        check(mem == 8'hFF, "R5", mem, 8'hFF);

        // R9: read error aborts without write
        lat = 1; err_rd = 1'b1;
        preload(8'h3C); run(3'd1, 9, 8'h22, 0, 8'hC3, seen);
        check(seen && err, "R9", err, 1);
        check(n_wr == 0 && mem == 8'h3C, "R9", mem, 8'h3C);
        err_rd = 1'b0;
        // R11: err persists while idle
        repeat (4) @(negedge clk);
        check(err && !done, "R11", err, 1);
        // R2: foreign opcodes ignored, no request, err kept
        for (int op = 0; op < 8; op++) begin
            if (op == 1) continue;
            preload(8'h3C);
            run(3'(op), 1, 8'h22, 0, 0, seen);
            check(!seen && !req_seen && !busy && err && mem == 8'h3C, "R2",
                  {seen, req_seen, busy, err}, 1);
        end
        // R11: next accepted start clears err
        preload(8'h3C); run(3'd1, 1, 8'h22, 0, 0, seen);
        check(seen && !err && mem == 8'h3D, "R11", {err, mem}, 8'h3D);

        // R10: write error ends operation with err
        err_wr = 1'b1; lat = 2;
        preload(8'h81); run(3'd1, 7, 8'h44, 0, 0, seen);
        check(seen && err && n_wr == 0 && mem == 8'h81, "R10", {err, mem}, 9'h181);
        check(n_rd == 1 && !order_bad, "R10", n_rd, 1);
        err_wr = 1'b0;
        @(negedge clk);
        check(!busy && !req, "R10", {busy, req}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule